// File: doc/BRIEF.md
# Two-Wire Timer Register Read Slave

This block is the serial front end of an interval-timer device on a two-wire bus. It oversamples and synchronizes the clock and data lines, finds start, repeated-start and stop conditions, and matches a fixed 7-bit device address. It takes a one-byte pointer in a write transaction and returns register bytes on a read. The read source is either the time register or a two-byte periodic-interrupt setting register. The setting register is chosen only when the pointer asks for it and the select-enable pin is high.

In normal use the master writes the pointer byte and then issues a repeated start with the read flag set, without a stop in between. Any stop condition sends the pointer back to the time register. Reads that run past the end of the selected register return bytes of all ones. The block drives the data line only through an open-drain pull-down enable.

The controller has these states: IDLE (bus free), ADDR (address byte coming in), PTR (pointer or later write byte coming in), ACK_SET (waiting for the low phase before the slave acknowledges), ACK_HOLD (acknowledge held through the ninth clock), TX_BIT (shifting a read byte out), TX_REL (letting go of the line after bit 0), TX_ACK (sampling the master's acknowledge), TX_LOAD (loading the next read byte) and IGNORE (silent until the next start). Transitions: a stop goes from any state to IDLE, and a start goes from any state to ADDR. ADDR goes to ACK_SET on a matching eighth bit, or to IGNORE on a mismatch. PTR goes to ACK_SET after its eighth bit. ACK_SET goes to ACK_HOLD on a clock fall. ACK_HOLD goes to TX_BIT for a read, or to PTR for a write. TX_BIT goes to TX_REL after its eighth bit. TX_REL goes to TX_ACK on a clock fall. TX_ACK goes to TX_LOAD on an acknowledge, or to IGNORE on a not-acknowledge. TX_LOAD goes to TX_BIT on a clock fall.

Top module: `tw_timer_rd_slave`

## Requirements
- R1: A start is data falling while clock is high, and a stop is data rising while clock is high. After a start the slave receives an address byte, and this holds even after an ignored transaction. A stop returns the slave to idle.
- R2: An address byte whose upper seven bits are 0110010 is acknowledged by holding data low through the ninth clock. Bit 0 of the address byte is the direction: 0 is write, 1 is read. Every byte written after the pointer is acknowledged too.
- R3: After an address mismatch the slave does not acknowledge that byte or any later byte until the next start.
- R4: The first byte after a write address is the pointer, and it is acknowledged. When its bit 0 is 1, bit 7 = 0 selects the setting register and bit 7 = 1 selects the time register. Bits 6 to 1 are don't-care.
- R5: A pointer byte with bit 0 = 0 is acknowledged, but the previously selected register stays selected.
- R6: With the setting register selected and the enable pin high, a read returns setting bits 15:8 first and then bits 7:0, each byte MSB first.
- R7: With the enable pin low, a read returns the time register whatever the pointer holds. The most significant byte of the time vector comes first.
- R8: Read bytes past the end of the selected register are 0xFF.
- R9: A stop selects the time register, so a read after a stop returns the time register.
- R10: After the master answers a read byte with a not-acknowledge, the slave stops driving data until the next start.
- R11: The slave changes its data drive only while the clock is low.
- R12: After reset the data drive is off and the time register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sel_en_i | input | 1 | Enable pin that allows the setting register to be read |
| time_reg_i | input | 8*TIME_BYTES | Time register contents, first-read byte in the top bits |
| cfg_reg_i | input | 8*CFG_BYTES | Setting register contents, first-read byte in the top bits |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |

## Verification
The bench builds the block with a three-byte time register, a two-byte setting register, two synchronizer stages and the default address. Because the two registers have different lengths, the all-ones fill past the end can be told apart for each source, and every bus phase fits well inside the synchronizer latency margin. With these values the bench can also show whether the first byte after a pointer, a repeated start, or a stop came from the setting register or from the time register.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_ACK_SET,
        ST_ACK_HOLD,
        ST_TX_BIT,
        ST_TX_REL,
        ST_TX_ACK,
        ST_TX_LOAD,
        ST_IGNORE
    } link_state_t;

    localparam logic [6:0] DEFAULT_DEV_ADDR = 7'b0110010;

endpackage

// File: rtl/tw_bus_mon.sv
module tw_bus_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic en_i,
    output logic scl_s,
    output logic sda_s,
    output logic en_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_q;
    logic [LAST:0] sda_q;
    logic [LAST:0] en_q;
    logic          scl_d;
    logic          sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            en_q  <= '0;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[LAST-1:0], scl_i};
            sda_q <= {sda_q[LAST-1:0], sda_i};
            en_q  <= {en_q[LAST-1:0], en_i};
            scl_d <= scl_q[LAST];
            sda_d <= sda_q[LAST];
        end
    end

    assign scl_s     = scl_q[LAST];
    assign sda_s     = sda_q[LAST];
    assign en_s      = en_q[LAST];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/tw_byte_pick.sv
module tw_byte_pick #(
    parameter int TIME_BYTES = 4,
    parameter int CFG_BYTES  = 2,
    parameter int IDXW       = 8
) (
    input  logic                    use_cfg,
    input  logic [IDXW-1:0]         idx,
    input  logic [8*TIME_BYTES-1:0] time_reg,
    input  logic [8*CFG_BYTES-1:0]  cfg_reg,
    output logic [7:0]              byte_o
);

    always_comb begin
        byte_o = 8'hFF;
        if (use_cfg) begin
            for (int i = 0; i < CFG_BYTES; i++) begin
                if (idx == IDXW'(i)) byte_o = cfg_reg[8*(CFG_BYTES-1-i) +: 8];
            end
        end else begin
            for (int i = 0; i < TIME_BYTES; i++) begin
                if (idx == IDXW'(i)) byte_o = time_reg[8*(TIME_BYTES-1-i) +: 8];
            end
        end
    end

endmodule

// File: rtl/tw_link_fsm.sv
module tw_link_fsm
    import tw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEFAULT_DEV_ADDR,
    parameter int         IDXW     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_s,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic [7:0]      pick_byte,
    output logic [IDXW-1:0] idx,
    output logic            sel_cfg,
    output logic            sda_oe
);

    link_state_t state, nxt;
    logic [7:0]  sh;
    logic [2:0]  cnt;
    logic        rd_dir;
    logic        first_wr;
    logic        last_bit;
    logic [7:0]  in_byte;

    assign last_bit = (cnt == 3'd7);
    assign in_byte  = {sh[6:0], sda_s};

    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_rise && last_bit)
                                 nxt = (in_byte[7:1] == DEV_ADDR) ? ST_ACK_SET : ST_IGNORE;
                ST_PTR:      if (scl_rise && last_bit) nxt = ST_ACK_SET;
                ST_ACK_SET:  if (scl_fall) nxt = ST_ACK_HOLD;
                ST_ACK_HOLD: if (scl_fall) nxt = rd_dir ? ST_TX_BIT : ST_PTR;
                ST_TX_BIT:   if (scl_rise && last_bit) nxt = ST_TX_REL;
                ST_TX_REL:   if (scl_fall) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_rise) nxt = sda_s ? ST_IGNORE : ST_TX_LOAD;
                ST_TX_LOAD:  if (scl_fall) nxt = ST_TX_BIT;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            cnt      <= '0;
            rd_dir   <= 1'b0;
            first_wr <= 1'b0;
            idx      <= '0;
            sel_cfg  <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            cnt     <= '0;
            sda_oe  <= 1'b0;
            sel_cfg <= 1'b0;
        end else if (start_det) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: if (scl_rise) begin
                    sh  <= in_byte;
                    cnt <= cnt + 3'd1;
                    if (last_bit) begin
                        rd_dir   <= sda_s;
                        first_wr <= 1'b1;
                        idx      <= '0;
                    end
                end
                ST_PTR: if (scl_rise) begin
                    sh  <= in_byte;
                    cnt <= cnt + 3'd1;
                    if (last_bit && first_wr) begin
                        first_wr <= 1'b0;
                        if (in_byte[0]) sel_cfg <= ~in_byte[7];
                    end
                end
                ST_ACK_SET: if (scl_fall) sda_oe <= 1'b1;
                ST_ACK_HOLD: if (scl_fall) begin
                    cnt <= '0;
                    if (rd_dir) begin
                        sh     <= pick_byte;
                        sda_oe <= ~pick_byte[7];
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
                ST_TX_BIT: begin
                    if (scl_rise) cnt <= cnt + 3'd1;
                    if (scl_fall) begin
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                    end
                end
                ST_TX_REL: if (scl_fall) sda_oe <= 1'b0;
                ST_TX_ACK: if (scl_rise && !sda_s && idx != '1) idx <= idx + 1'b1;
                ST_TX_LOAD: if (scl_fall) begin
                    cnt    <= '0;
                    sh     <= pick_byte;
                    sda_oe <= ~pick_byte[7];
                end
                default: ;
            endcase
        end
    end

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // R2
    ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_HOLD) |-> sda_oe);

    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R9
    stop_clears_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sel_cfg);

    // R4
    ptr_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_cfg) |-> ($past(state) == ST_PTR || $past(stop_det)));

endmodule

// File: rtl/tw_timer_rd_slave.sv
module tw_timer_rd_slave
    import tw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = DEFAULT_DEV_ADDR,
    parameter int         TIME_BYTES  = 4,
    parameter int         CFG_BYTES   = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    sel_en_i,
    input  logic [8*TIME_BYTES-1:0] time_reg_i,
    input  logic [8*CFG_BYTES-1:0]  cfg_reg_i,
    output logic                    sda_oe_o
);

    localparam int IDXW = 8;

    logic            scl_s, sda_s, en_s;
    logic            scl_rise, scl_fall, start_det, stop_det;
    logic [IDXW-1:0] idx;
    logic            sel_cfg;
    logic [7:0]      pick_byte;

    tw_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) i_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .en_i      (sel_en_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .en_s      (en_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_byte_pick #(
        .TIME_BYTES (TIME_BYTES),
        .CFG_BYTES  (CFG_BYTES),
        .IDXW       (IDXW)
    ) i_pick (
        .use_cfg  (sel_cfg & en_s),
        .idx      (idx),
        .time_reg (time_reg_i),
        .cfg_reg  (cfg_reg_i),
        .byte_o   (pick_byte)
    );

    tw_link_fsm #(.DEV_ADDR(DEV_ADDR), .IDXW(IDXW)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .pick_byte (pick_byte),
        .idx       (idx),
        .sel_cfg   (sel_cfg),
        .sda_oe    (sda_oe_o)
    );

endmodule

// File: tb/test_tw_timer_rd_slave.sv
module test_tw_timer_rd_slave;

    localparam int         TB_TIME_BYTES = 3;
    localparam int         TB_CFG_BYTES  = 2;
    localparam int         HALF          = 10;
    localparam logic [7:0] ADDR_W        = 8'h64;
    localparam logic [7:0] ADDR_R        = 8'h65;
    localparam logic [23:0] TIME_VAL     = 24'h12_34_56;
    localparam logic [15:0] CFG_VAL      = 16'hA5_3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sel_en = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   n_run = 0;
    int   n_fail = 0;
    int   r11_viol = 0;
    logic oe_prev = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    tw_timer_rd_slave #(
        .TIME_BYTES  (TB_TIME_BYTES),
        .CFG_BYTES   (TB_CFG_BYTES),
        .SYNC_STAGES (2)
    ) i_tw_timer_rd_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sel_en_i   (sel_en),
        .time_reg_i (TIME_VAL),
        .cfg_reg_i  (CFG_VAL),
        .sda_oe_o   (sda_oe)
    );

    // R11 monitor: drive may change only while the clock line is low
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe !== oe_prev)) r11_viol++;
        oe_prev <= sda_oe;
    end

    typedef struct packed {
        logic       en;
        logic [7:0] ptr;
        logic       restart;
        logic [2:0] nread;
        logic       exp_cfg;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{1'b1, 8'h01, 1'b1, 3'd3, 1'b1},
        '{1'b0, 8'h01, 1'b1, 3'd4, 1'b0},
        '{1'b1, 8'h81, 1'b1, 3'd2, 1'b0},
        '{1'b1, 8'h01, 1'b0, 3'd2, 1'b0},
        '{1'b1, 8'h7F, 1'b1, 3'd3, 1'b1}
    };

    function automatic logic [7:0] exp_byte(input logic cfg, input int k);
        if (cfg) return (k < 2) ? CFG_VAL[8*(1-k) +: 8] : 8'hFF;
        return (k < 3) ? TIME_VAL[8*(2-k) +: 8] : 8'hFF;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h, expected %h", req, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half_wait();
        scl_m = 1'b1; half_wait();
        sda_m = 1'b0; half_wait();
        scl_m = 1'b0; half_wait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half_wait();
        scl_m = 1'b1; half_wait();
        sda_m = 1'b1; half_wait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; half_wait();
        scl_m = 1'b1; half_wait();
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic r);
        sda_m = 1'b1; half_wait();
        scl_m = 1'b1;
        repeat (HALF/2) @(negedge clk);
        r = sda_line;
        repeat (HALF - HALF/2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(nack);
    endtask

    task automatic read_byte(output logic [7:0] b, input logic nack);
        for (int i = 7; i >= 0; i--) recv_bit(b[i]);
        send_bit(nack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        check("R12 drive off in reset", {7'b0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R12 drive off after reset", {7'b0, sda_oe}, 8'h00);

        // R12: default pointer selects the time register
        bus_start();
        write_byte(ADDR_R, a);
        check("R2 read address ack", {7'b0, a}, 8'h00);
        for (int k = 0; k < 2; k++) begin
            read_byte(d, k == 1);
            check("R12 default time read", d, exp_byte(1'b0, k));
        end
        bus_stop();

        // table walk
        for (int v = 0; v < 5; v++) begin
            sel_en = VEC[v].en;
            bus_start();
            write_byte(ADDR_W, a);
            check("R2 write address ack", {7'b0, a}, 8'h00);
            write_byte(VEC[v].ptr, a);
            check("R4 pointer ack", {7'b0, a}, 8'h00);
            if (!VEC[v].restart) bus_stop();
            bus_start();
            write_byte(ADDR_R, a);
            check("R2 read address ack", {7'b0, a}, 8'h00);
            for (int k = 0; k < int'(VEC[v].nread); k++) begin
                read_byte(d, k == int'(VEC[v].nread) - 1);
                if (k >= (VEC[v].exp_cfg ? 2 : 3))
                    check("R8 read past end", d, exp_byte(VEC[v].exp_cfg, k));
                else if (VEC[v].exp_cfg)
                    check("R6 setting read", d, exp_byte(1'b1, k));
                else if (!VEC[v].en)
                    check("R7 enable low time read", d, exp_byte(1'b0, k));
                else if (!VEC[v].restart)
                    check("R9 time after stop", d, exp_byte(1'b0, k));
                else
                    check("R4 pointer bit7 set time read", d, exp_byte(1'b0, k));
            end
            bus_stop();
        end
        sel_en = 1'b1;

        // R3: mismatched address, no ack for it or a following byte
        bus_start();
        write_byte(8'h66, a);
        check("R3 mismatch no ack", {7'b0, a}, 8'h01);
        write_byte(8'h01, a);
        check("R3 later byte no ack", {7'b0, a}, 8'h01);
        // R1: a new start recovers
        bus_start();
        write_byte(ADDR_W, a);
        check("R1 start after ignore ack", {7'b0, a}, 8'h00);
        write_byte(8'h01, a);
        check("R4 pointer ack", {7'b0, a}, 8'h00);
        write_byte(8'h55, a);
        check("R2 extra write byte ack", {7'b0, a}, 8'h00);
        // R5: pointer with test bit 0 keeps setting selection
        bus_start();
        write_byte(ADDR_W, a);
        write_byte(8'h80, a);
        check("R5 test bit clear still acked", {7'b0, a}, 8'h00);
        bus_start();
        write_byte(ADDR_R, a);
        for (int k = 0; k < 2; k++) begin
            read_byte(d, k == 1);
            check("R5 pointer unchanged", d, exp_byte(1'b1, k));
        end
        bus_stop();

        // R10: after NACK the slave stays off the line
        bus_start();
        write_byte(ADDR_W, a);
        write_byte(8'h01, a);
        bus_start();
        write_byte(ADDR_R, a);
        read_byte(d, 1'b1);
        check("R6 first setting byte", d, 8'hA5);
        read_byte(d, 1'b1);
        check("R10 silent after nack", d, 8'hFF);
        bus_stop();

        n_run++;
        if (r11_viol != 0) begin
            n_fail++;
            $display("FAIL R11 drive changed with clock high: got %0d, expected 0", r11_viol);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule